// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block sits in front of a page-table walker. For every memory access it decides whether the address falls inside one of four programmable windows whose addresses pass through untranslated. Two windows serve instruction fetches and two serve data accesses. A window compares the top byte of the address against a programmable base. A per-bit ignore mask can widen the window to any power-of-two-aligned group of 16 MiB regions, and a privilege selector restricts the window to user accesses, to supervisor accesses, or to both.

On a hit the block returns the logical page number as the physical page number, together with read, execute and (unless write-protected) write permission and the window's cache mode. On a miss it raises a walk request so the table walker takes over. Probe accesses that hit a window also produce the status flags that mark the result as transparent and resident. Window registers are loaded through a simple indexed write port. The access path is combinational from the stored windows, so a new window value governs the access presented in the cycle after the write edge.

Top module: `xwin_match`

## Requirements
- R1: After reset all four windows read as zero, so every valid access misses and raises `walk_req`.
- R2: A write with `cfg_we` high stores `cfg_wdata` into window `cfg_idx` at the clock edge. Index 0 and 1 are the instruction windows 0 and 1, and index 2 and 3 are the data windows 0 and 1. The new value affects accesses only after that edge.
- R3: A window whose enable bit (bit 15) is clear never matches, whatever its other fields hold.
- R4: The privilege selector in bits 14:13 decides which accesses a window matches. Value 00 matches only user accesses (`acc_super` low), 01 matches only supervisor accesses, and 10 or 11 match both.
- R5: A window matches an address when `acc_addr[31:24]` equals the base in bits 31:24 on every bit position whose ignore-mask bit (bits 23:16) is 0. Mask bits set to 1 drop that position, and address bits 23:0 never affect matching.
- R6: Accesses with `acc_code` high consult only the instruction windows, and other accesses consult only the data windows.
- R7: When both windows of the consulted pair match, window 0 wins. `hit_slot` gives the winning window within its pair (0 or 1).
- R8: On a hit `perm_read` and `perm_exec` are 1, and `perm_write` is 1 only when the window's write-protect bit (bit 2) is 0. `store_denied` is 1 for a hit by a store (`acc_store`) on a write-protected window. The store flag changes nothing else. On a miss all four are 0.
- R9: On a hit `phys_page` equals `acc_addr[31:12]` and `cache_mode` equals the winning window's bits 6:5. On a miss both are 0.
- R10: With `acc_valid` high exactly one of `tt_hit` and `walk_req` is 1. With `acc_valid` low every output is 0.
- R11: A probe access (`acc_probe`) that hits sets `probe_flags` to 2'b11 (bit 1 transparent, bit 0 resident). Otherwise `probe_flags` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_idx | input | 2 | Window register index |
| cfg_wdata | input | 32 | Window register write value |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Logical access address |
| acc_super | input | 1 | Access is in supervisor mode |
| acc_code | input | 1 | Access is an instruction fetch |
| acc_store | input | 1 | Access is a store |
| acc_probe | input | 1 | Access is a translation probe |
| tt_hit | output | 1 | Access hit a transparent window |
| walk_req | output | 1 | Access missed; table walk needed |
| hit_slot | output | 1 | Winning window within its pair |
| phys_page | output | 20 | Physical page number on a hit |
| perm_read | output | 1 | Read permitted |
| perm_write | output | 1 | Write permitted |
| perm_exec | output | 1 | Execute permitted |
| store_denied | output | 1 | Store hit a write-protected window |
| cache_mode | output | 2 | Cache mode of the winning window |
| probe_flags | output | 2 | Probe status flags {transparent, resident} |

## Verification
Under each of three window setups, every value of the top address byte is combined with all sixteen settings of the privilege, kind, store and probe flags. The setups are the reset state, a setup with two overlapping instruction windows of different privilege and protection beside a disabled data window with a wide mask, and a setup where a disabled window would otherwise match everything. The overlap separates the priority order from a plain OR of matches, and the mixed selectors separate the user-only, supervisor-only and don't-care cases. Varying the low address bits with the top byte shows that they reach only the page number and never the match. A write is also watched across its clock edge to pin down when it takes effect, and an idle sweep confirms that the outputs stay quiet.

// File: rtl/xwin_pkg.sv
package xwin_pkg;

  localparam int REG_W    = 32;
  localparam int CMP_W    = 8;
  localparam int BASE_LSB = 24;
  localparam int MASK_LSB = 16;
  localparam int EN_BIT   = 15;
  localparam int PRIV_LSB = 13;
  localparam int CM_LSB   = 5;
  localparam int WP_BIT   = 2;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_ANY_A = 2'b10,
    PRIV_ANY_B = 2'b11
  } priv_sel_e;

  typedef struct packed {
    logic [CMP_W-1:0] base;
    logic [CMP_W-1:0] ignore;
    logic             en;
    priv_sel_e        priv;
    logic [1:0]       cmode;
    logic             wprot;
  } win_cfg_t;

  function automatic win_cfg_t unpack_win(input logic [REG_W-1:0] r);
    win_cfg_t c;
    c.base   = r[BASE_LSB +: CMP_W];
    c.ignore = r[MASK_LSB +: CMP_W];
    c.en     = r[EN_BIT];
    c.priv   = priv_sel_e'(r[PRIV_LSB +: 2]);
    c.cmode  = r[CM_LSB +: 2];
    c.wprot  = r[WP_BIT];
    return c;
  endfunction

  function automatic logic priv_ok(input priv_sel_e p, input logic sup);
    case (p)
      PRIV_USER:  return !sup;
      PRIV_SUPER: return sup;
      default:    return 1'b1;
    endcase
  endfunction

  function automatic logic field_eq(input logic [CMP_W-1:0] a,
                                    input logic [CMP_W-1:0] base,
                                    input logic [CMP_W-1:0] ignore);
    logic [CMP_W-1:0] care;
    care = ~ignore;
    return (a & care) == (base & care);
  endfunction

endpackage

// File: rtl/xwin_regs.sv
module xwin_regs #(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_WIN-1:0][DATA_W-1:0]   win_q
);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_q[i] <= '0;
      end else if (we && (idx == IDX_W'(i))) begin
        win_q[i] <= wdata;
      end
    end
  end

endmodule

// File: rtl/xwin_unit.sv
module xwin_unit
  import xwin_pkg::*;
(
  input  logic [REG_W-1:0] win_raw,
  input  logic [CMP_W-1:0] addr_hi,
  input  logic             sup,
  output logic             match,
  output logic             wprot,
  output logic [1:0]       cmode
);

  win_cfg_t cfg;
  logic     mode_ok;
  logic     addr_ok;
  logic     unused_bits;

  assign cfg         = unpack_win(win_raw);
  assign mode_ok     = priv_ok(cfg.priv, sup);
  assign addr_ok     = field_eq(addr_hi, cfg.base, cfg.ignore);
  assign match       = cfg.en && mode_ok && addr_ok;
  assign wprot       = cfg.wprot;
  assign cmode       = cfg.cmode;
  assign unused_bits = ^{win_raw[12:7], win_raw[4:3], win_raw[1:0]};

endmodule

// File: rtl/xwin_pick.sv
module xwin_pick #(
  parameter int WIN_PER_KIND = 2,
  localparam int NUM_WIN     = 2 * WIN_PER_KIND,
  localparam int SLOT_W      = (WIN_PER_KIND > 1) ? $clog2(WIN_PER_KIND) : 1
) (
  input  logic [NUM_WIN-1:0]      match,
  input  logic [NUM_WIN-1:0]      wprot,
  input  logic [NUM_WIN-1:0][1:0] cmode,
  input  logic                    code,
  output logic                    hit,
  output logic [SLOT_W-1:0]       slot,
  output logic                    wp,
  output logic [1:0]              cm
);

  always_comb begin
    int off;
    off  = code ? 0 : WIN_PER_KIND;
    hit  = 1'b0;
    slot = '0;
    wp   = 1'b0;
    cm   = '0;
    for (int k = WIN_PER_KIND - 1; k >= 0; k--) begin
      if (match[off + k]) begin
        hit  = 1'b1;
        slot = SLOT_W'(k);
        wp   = wprot[off + k];
        cm   = cmode[off + k];
      end
    end
  end

endmodule

// File: rtl/xwin_match.sv
module xwin_match
  import xwin_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int PAGE_BITS    = 12,
  parameter int WIN_PER_KIND = 2,
  localparam int NUM_WIN     = 2 * WIN_PER_KIND,
  localparam int IDX_W       = $clog2(NUM_WIN),
  localparam int SLOT_W      = (WIN_PER_KIND > 1) ? $clog2(WIN_PER_KIND) : 1,
  localparam int PPN_W       = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_super,
  input  logic              acc_code,
  input  logic              acc_store,
  input  logic              acc_probe,
  output logic              tt_hit,
  output logic              walk_req,
  output logic [SLOT_W-1:0] hit_slot,
  output logic [PPN_W-1:0]  phys_page,
  output logic              perm_read,
  output logic              perm_write,
  output logic              perm_exec,
  output logic              store_denied,
  output logic [1:0]        cache_mode,
  output logic [1:0]        probe_flags
);

  logic [NUM_WIN-1:0][REG_W-1:0] win_q;
  logic [NUM_WIN-1:0]            win_match;
  logic [NUM_WIN-1:0]            win_wp;
  logic [NUM_WIN-1:0][1:0]       win_cm;
  logic                          pick_hit;
  logic [SLOT_W-1:0]             pick_slot;
  logic                          pick_wp;
  logic [1:0]                    pick_cm;
  logic                          unused_low;

  xwin_regs #(.NUM_WIN(NUM_WIN), .DATA_W(REG_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .wdata (cfg_wdata),
    .win_q (win_q)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_unit
    xwin_unit u_unit (
      .win_raw (win_q[i]),
      .addr_hi (acc_addr[ADDR_W-1 -: CMP_W]),
      .sup     (acc_super),
      .match   (win_match[i]),
      .wprot   (win_wp[i]),
      .cmode   (win_cm[i])
    );
  end

  xwin_pick #(.WIN_PER_KIND(WIN_PER_KIND)) u_pick (
    .match (win_match),
    .wprot (win_wp),
    .cmode (win_cm),
    .code  (acc_code),
    .hit   (pick_hit),
    .slot  (pick_slot),
    .wp    (pick_wp),
    .cm    (pick_cm)
  );

  assign tt_hit       = acc_valid && pick_hit;
  assign walk_req     = acc_valid && !pick_hit;
  assign hit_slot     = tt_hit ? pick_slot : '0;
  assign phys_page    = tt_hit ? acc_addr[ADDR_W-1:PAGE_BITS] : '0;
  assign perm_read    = tt_hit;
  assign perm_exec    = tt_hit;
  assign perm_write   = tt_hit && !pick_wp;
  assign store_denied = tt_hit && pick_wp && acc_store;
  assign cache_mode   = tt_hit ? pick_cm : 2'b00;
  assign probe_flags  = (tt_hit && acc_probe) ? 2'b11 : 2'b00;
  assign unused_low   = ^acc_addr[PAGE_BITS-1:0];

endmodule

// File: rtl/xwin_match_chk.sv
module xwin_match_chk #(
  parameter int WIN_PER_KIND = 2,
  parameter int REG_W        = 32,
  parameter int EN_BIT       = 15,
  localparam int NUM_WIN     = 2 * WIN_PER_KIND,
  localparam int IDX_W       = $clog2(NUM_WIN),
  localparam int SLOT_W      = (WIN_PER_KIND > 1) ? $clog2(WIN_PER_KIND) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_we,
  input logic [IDX_W-1:0]              cfg_idx,
  input logic [REG_W-1:0]              cfg_wdata,
  input logic [NUM_WIN-1:0][REG_W-1:0] win_q,
  input logic [NUM_WIN-1:0]            win_match,
  input logic                          acc_valid,
  input logic                          acc_code,
  input logic                          acc_probe,
  input logic                          tt_hit,
  input logic                          walk_req,
  input logic [SLOT_W-1:0]             hit_slot,
  input logic                          perm_read,
  input logic                          perm_write,
  input logic                          perm_exec,
  input logic                          store_denied,
  input logic [1:0]                    probe_flags
);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> win_q[$past(cfg_idx)] == $past(cfg_wdata));

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_dis
    assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !win_q[i][EN_BIT] |-> !win_match[i]);
  end

  assert_code_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tt_hit && acc_code) |-> |win_match[WIN_PER_KIND-1:0]);

  assert_data_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tt_hit && !acc_code) |-> |win_match[NUM_WIN-1:WIN_PER_KIND]);

  assert_slot0_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tt_hit && hit_slot != '0) |->
      !(acc_code ? win_match[0] : win_match[WIN_PER_KIND]));

  assert_perm_on_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_read || perm_write || perm_exec || store_denied) |-> tt_hit);

  assert_write_implies_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    perm_write |-> (perm_read && perm_exec && !store_denied));

  assert_hit_or_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $onehot({tt_hit, walk_req}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !(tt_hit || walk_req));

  assert_probe_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_flags != 2'b00) |-> (tt_hit && acc_probe && probe_flags == 2'b11));

endmodule

bind xwin_match xwin_match_chk #(.WIN_PER_KIND(WIN_PER_KIND)) u_chk (.*);

// File: tb/test_xwin_match.sv
module test_xwin_match;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        acc_super, acc_code, acc_store, acc_probe;
  logic        tt_hit, walk_req;
  logic [0:0]  hit_slot;
  logic [19:0] phys_page;
  logic        perm_read, perm_write, perm_exec, store_denied;
  logic [1:0]  cache_mode, probe_flags;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  xwin_match i_xwin_match (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_super(acc_super), .acc_code(acc_code), .acc_store(acc_store),
    .acc_probe(acc_probe), .tt_hit(tt_hit), .walk_req(walk_req),
    .hit_slot(hit_slot), .phys_page(phys_page), .perm_read(perm_read),
    .perm_write(perm_write), .perm_exec(perm_exec),
    .store_denied(store_denied), .cache_mode(cache_mode),
    .probe_flags(probe_flags)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h addr=%08h sup=%0b code=%0b",
               req, act, exp, acc_addr, acc_super, acc_code);
    end
  endtask

  // bench model of one window: bit by bit over the top byte
  function automatic logic win_hits(input logic [31:0] w, input logic [7:0] hi,
                                    input logic sup);
    if (w[15] == 1'b0) return 1'b0;
    if (w[14:13] == 2'b00 && sup) return 1'b0;
    if (w[14:13] == 2'b01 && !sup) return 1'b0;
    for (int b = 0; b < 8; b++)
      if (w[16+b] == 1'b0 && hi[b] != w[24+b]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic wr(input int idx, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    model[idx] = val;
  endtask

  task automatic check_now(input string tag);
    int  lo;
    logic eh, es, ewp;
    logic [1:0] ecm;
    lo = acc_code ? 0 : 2;
    eh = 1'b0; es = 1'b0; ewp = 1'b0; ecm = 2'b00;
    if (acc_valid) begin
      if (win_hits(model[lo], acc_addr[31:24], acc_super)) begin
        eh = 1'b1; ewp = model[lo][2]; ecm = model[lo][6:5];
      end else if (win_hits(model[lo+1], acc_addr[31:24], acc_super)) begin
        eh = 1'b1; es = 1'b1; ewp = model[lo+1][2]; ecm = model[lo+1][6:5];
      end
    end
    chk({tag, " hit"}, 64'(tt_hit), 64'(eh));
    chk("R10 walk", 64'(walk_req), 64'(acc_valid && !eh));
    chk("R7 slot", 64'(hit_slot), 64'(es));
    chk("R8 perm", 64'({perm_read, perm_write, perm_exec, store_denied}),
        64'({eh, eh && !ewp, eh, eh && ewp && acc_store}));
    chk("R9 page", 64'({phys_page, cache_mode}),
        64'({eh ? acc_addr[31:12] : 20'h0, ecm}));
    chk("R11 probe", 64'(probe_flags), 64'((eh && acc_probe) ? 2'b11 : 2'b00));
  endtask

  task automatic sweep(input string tag, input logic valid);
    for (int hi = 0; hi < 256; hi++) begin
      for (int at = 0; at < 16; at++) begin
        @(negedge clk);
        acc_valid = valid;
        acc_addr  = {8'(hi), 24'(hi * 32'h1F3 + at * 32'h5A5A5)};
        {acc_super, acc_code, acc_store, acc_probe} = 4'(at);
        #1;
        check_now(tag);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0;
    {acc_super, acc_code, acc_store, acc_probe} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 idle outputs", 64'({tt_hit, walk_req, probe_flags}), 64'(0));

    // R1: reset windows miss everything
    sweep("R1", 1'b1);

    // R2: write visible only after its edge (data window 1, any priv, full mask)
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd3; cfg_wdata = 32'h00FFC000;
    acc_valid = 1'b1; acc_addr = 32'h5500_1000; acc_code = 1'b0; acc_super = 1'b0;
    #1;
    chk("R2 before edge", 64'(tt_hit), 64'(0));
    @(negedge clk);
    cfg_we = 1'b0; model[3] = 32'h00FFC000;
    #1;
    chk("R2 after edge", 64'({tt_hit, hit_slot}), 64'({1'b1, 1'b1}));

    // Setup B: overlapping instruction windows, supervisor data window,
    // disabled wide data window (R3 R4 R5 R6 R7)
    wr(0, 32'h400FC020);
    wr(1, 32'h40FF8044);
    wr(2, 32'h8000A064);
    wr(3, 32'hC33C4000);
    sweep("R3 R4 R5 R6 R7", 1'b1);
    sweep("R10 idle", 1'b0);

    // Setup C: disabled catch-all, selector 11, user-only data window
    wr(0, 32'h00FF6000);
    wr(1, 32'h807FE000);
    wr(2, 32'h80008004);
    wr(3, 32'hC33CC020);
    sweep("R3 R4 R5 R6", 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule